// File: doc/BRIEF.md
# Port LED Blink and Activity-Stretch Timer

This block is the timing source behind the indicator LEDs of one switch port. Software writes a blink-rate code and a pulse-stretch code through the port's indirect LED control register. The write is taken only at the timing pointer value and only while the update flag is set. From a 1 ms tick, the block builds a forced-blink waveform. The period of that waveform follows the rate code on a 21·2^n ms ladder. Its on-time within each period follows the stretch code.

The same stretch setting also lengthens raw activity pulses so that a single-cycle event is seen as a visible flash. Both settings are shared by every LED of the port. The selector that routes these waveforms to the LED pins is outside this block.

Top module: `led_blink_stretch_gen`

## Requirements
- R1: The codes are loaded on a clock where `wr_en`, `wr_update` and `wr_pointer == 6` are all true. Any write that misses one of these conditions leaves both codes, and so both outputs, unchanged.
- R2: The blink-rate code is taken from `wr_data[2:0]`. Code n (0..5) selects a period of 21·2^n ms. Codes 6 and 7 behave as code 5 (672 ms).
- R3: The stretch code is taken from `wr_data[6:4]`. Codes 0..4 select 0, 21, 42, 84 and 168 ms. Codes 5..7 behave as code 4 (168 ms).
- R4: `blink_out` is high for the first on-time milliseconds of each period and low for the rest of it. With stretch code 0 it is always low.
- R5: When the on-time is equal to or longer than the period, `blink_out` stays high continuously.
- R6: The position within the period is a free-running millisecond count taken modulo the period. The count wraps at 672 and is not reset by a code change, so all rates stay phase-aligned.
- R7: `act_stretched` rises on the clock after `act_raw`. It stays high until as many ms ticks as the stretch time have passed with no new activity. A new pulse restarts that time.
- R8: With stretch code 0, each activity pulse gives `act_stretched` high for exactly one clock.
- R9: Reset (asynchronous, active low) clears both codes and all counters, and drives both outputs low.
- R10: The millisecond position advances only on clocks where `ms_tick` is high.
- R11: Both outputs are registered. `blink_out` reflects the position and codes held before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_update | input | 1 | Update flag of the write |
| wr_pointer | input | 3 | Indirect sub-register pointer |
| wr_data | input | 11 | Write data |
| act_raw | input | 1 | Raw activity pulse |
| blink_out | output | 1 | Forced-blink waveform |
| act_stretched | output | 1 | Stretched activity indication |

## Verification
The bench builds the block with its default parameters: a 21 ms base, five doublings and four stretch steps. It drives `ms_tick` on every clock, or on every second clock, instead of once per real millisecond. As a result, the full 672 ms ladder and each stretch hold wrap many times within a few thousand clocks. This makes every rate and stretch code, the saturated codes, and the on-time-covers-period cases reachable. It also makes a rate change in mid-period reachable, which exposes any loss of phase alignment.

// File: rtl/led_tim_pkg.sv
package led_tim_pkg;
  localparam int PTR_W       = 3;
  localparam int DATA_W      = 11;
  localparam int CODE_W      = 3;
  localparam logic [PTR_W-1:0] PTR_TIMING = 3'd6;
  localparam int RATE_LSB    = 0;
  localparam int STRETCH_LSB = 4;
endpackage

// File: rtl/led_tim_cfg.sv
module led_tim_cfg
  import led_tim_pkg::*;
#(
  parameter int RATE_MAX    = 5,
  parameter int STRETCH_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_update,
  input  logic [PTR_W-1:0]  wr_pointer,
  input  logic [CODE_W-1:0] rate_field,
  input  logic [CODE_W-1:0] stretch_field,
  output logic [CODE_W-1:0] rate_q,
  output logic [CODE_W-1:0] stretch_q
);
  logic              load;
  logic [CODE_W-1:0] rate_d;
  logic [CODE_W-1:0] stretch_d;

  always_comb begin
    load      = wr_en && wr_update && (wr_pointer == PTR_TIMING);
    rate_d    = rate_q;
    stretch_d = stretch_q;
    if (load) begin
      rate_d    = (int'(rate_field) > RATE_MAX) ? CODE_W'(RATE_MAX) : rate_field;
      stretch_d = (int'(stretch_field) > STRETCH_MAX) ? CODE_W'(STRETCH_MAX) : stretch_field;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q    <= '0;
      stretch_q <= '0;
    end else begin
      rate_q    <= rate_d;
      stretch_q <= stretch_d;
    end
  end

  assert_ignore_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_update && (wr_pointer == PTR_TIMING)) |=> ($stable(rate_q) && $stable(stretch_q)));
  assert_rate_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rate_q) <= RATE_MAX);
  assert_stretch_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stretch_q) <= STRETCH_MAX);
endmodule

// File: rtl/led_tim_phase.sv
module led_tim_phase
  import led_tim_pkg::*;
#(
  parameter int BASE_MS  = 21,
  parameter int RATE_MAX = 5,
  localparam int BASE_W  = $clog2(BASE_MS),
  localparam int SEG_W   = RATE_MAX,
  localparam int POS_W   = $clog2((BASE_MS << RATE_MAX) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [CODE_W-1:0] rate_q,
  output logic [POS_W-1:0]  pos,
  output logic [POS_W-1:0]  period
);
  logic [BASE_W-1:0] base_q, base_d;
  logic [SEG_W-1:0]  seg_q, seg_d;
  logic [SEG_W-1:0]  seg_mask;

  always_comb begin
    base_d = base_q;
    seg_d  = seg_q;
    if (ms_tick) begin
      if (int'(base_q) == BASE_MS - 1) begin
        base_d = '0;
        seg_d  = seg_q + 1'b1;
      end else begin
        base_d = base_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      seg_q  <= '0;
    end else begin
      base_q <= base_d;
      seg_q  <= seg_d;
    end
  end

  for (genvar i = 0; i < SEG_W; i++) begin : g_mask
    assign seg_mask[i] = (i < int'(rate_q));
  end

  always_comb begin
    pos    = POS_W'(seg_q & seg_mask) * POS_W'(BASE_MS) + POS_W'(base_q);
    period = POS_W'(BASE_MS) << rate_q;
  end

  assert_base_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(base_q) < BASE_MS);
  assert_tick_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> ($stable(base_q) && $stable(seg_q)));
  assert_pos_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos < period);
endmodule

// File: rtl/led_act_stretch.sv
module led_act_stretch #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              act_raw,
  input  logic [HOLD_W-1:0] hold_ms,
  output logic              act_out
);
  logic              flag_q, flag_d;
  logic [HOLD_W-1:0] timer_q, timer_d;
  logic              expire;

  always_comb begin
    flag_d  = flag_q;
    timer_d = timer_q;
    expire  = (timer_q == '0) || (ms_tick && (timer_q == HOLD_W'(1)));
    if (act_raw) begin
      flag_d  = 1'b1;
      timer_d = hold_ms;
    end else if (flag_q && expire) begin
      flag_d  = 1'b0;
      timer_d = '0;
    end else if (ms_tick && (timer_q != '0)) begin
      timer_d = timer_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      timer_q <= '0;
    end else begin
      flag_q  <= flag_d;
      timer_q <= timer_d;
    end
  end

  assign act_out = flag_q;

  assert_act_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_raw |=> act_out);
  assert_act_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_out) |-> !$past(act_raw));
  assert_zero_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_out && !act_raw && (timer_q == '0)) |=> !act_out);
endmodule

// File: rtl/led_blink_stretch_gen.sv
module led_blink_stretch_gen
  import led_tim_pkg::*;
#(
  parameter int BASE_MS     = 21,
  parameter int RATE_MAX    = 5,
  parameter int STRETCH_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              wr_en,
  input  logic              wr_update,
  input  logic [PTR_W-1:0]  wr_pointer,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              act_raw,
  output logic              blink_out,
  output logic              act_stretched
);
  localparam int POS_W  = $clog2((BASE_MS << RATE_MAX) + 1);
  localparam int HOLD_W = $clog2((BASE_MS << (STRETCH_MAX - 1)) + 1);

  logic [CODE_W-1:0] rate_q, stretch_q;
  logic [POS_W-1:0]  pos, period;
  logic [HOLD_W-1:0] on_ms;
  logic              on_covers;
  logic              blink_d, blink_q;
  logic              data_unused;

  assign data_unused = ^{wr_data[DATA_W-1:STRETCH_LSB+CODE_W], wr_data[STRETCH_LSB-1:RATE_LSB+CODE_W]};

  led_tim_cfg #(.RATE_MAX(RATE_MAX), .STRETCH_MAX(STRETCH_MAX)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_update(wr_update),
    .wr_pointer(wr_pointer),
    .rate_field(wr_data[RATE_LSB +: CODE_W]),
    .stretch_field(wr_data[STRETCH_LSB +: CODE_W]),
    .rate_q(rate_q), .stretch_q(stretch_q)
  );

  led_tim_phase #(.BASE_MS(BASE_MS), .RATE_MAX(RATE_MAX)) phase_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rate_q(rate_q),
    .pos(pos), .period(period)
  );

  always_comb begin
    on_ms     = (stretch_q == '0) ? '0 : (HOLD_W'(BASE_MS) << (stretch_q - 1'b1));
    on_covers = (POS_W'(on_ms) >= period);
    blink_d   = (pos < POS_W'(on_ms));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blink_q <= 1'b0;
    else        blink_q <= blink_d;
  end

  assign blink_out = blink_q;

  led_act_stretch #(.HOLD_W(HOLD_W)) stretch_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .act_raw(act_raw),
    .hold_ms(on_ms), .act_out(act_stretched)
  );

  assert_off_when_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch_q == '0) |=> !blink_out);
  assert_solid_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    on_covers |=> blink_out);
endmodule

// File: tb/led_blink_stretch_gen_tb_top.sv
module led_blink_stretch_gen_tb_top;
  localparam int BASE = 21;
  localparam int FULL = BASE << 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic wr_en = 1'b0;
  logic wr_update = 1'b0;
  logic [2:0] wr_pointer = '0;
  logic [10:0] wr_data = '0;
  logic act_raw = 1'b0;
  logic blink_out, act_stretched;

  always #5 clk = ~clk;

  led_blink_stretch_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_en(wr_en),
    .wr_update(wr_update), .wr_pointer(wr_pointer), .wr_data(wr_data),
    .act_raw(act_raw), .blink_out(blink_out), .act_stretched(act_stretched)
  );

  int errors = 0;
  int checks = 0;
  string cur_req = "R9";
  bit compare_on = 1'b0;
  int cycles = 0;

  // behavioural reference
  int m_ms = 0, m_rate = 0, m_str = 0, m_since = 0;
  bit e_blink = 0, e_act = 0;

  function automatic int on_time(int s);
    return (s == 0) ? 0 : (BASE << (s - 1));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ms = 0; m_rate = 0; m_str = 0; m_since = 0; e_blink = 0; e_act = 0;
    end else begin
      e_blink = (m_ms % (BASE << m_rate)) < on_time(m_str);
      if (act_raw) begin
        e_act = 1; m_since = 0;
      end else if (e_act) begin
        if (ms_tick) m_since++;
        if (m_since >= on_time(m_str)) e_act = 0;
      end
      if (ms_tick) m_ms = (m_ms + 1) % FULL;
      if (wr_en && wr_update && wr_pointer == 3'd6) begin
        m_rate = (wr_data[2:0] > 5) ? 5 : int'(wr_data[2:0]);
        m_str  = (wr_data[6:4] > 4) ? 4 : int'(wr_data[6:4]);
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      checks++;
      if (blink_out !== e_blink) begin
        errors++;
        $display("FAIL %s blink_out actual=%0b expected=%0b at cycle %0d", cur_req, blink_out, e_blink, cycles);
      end
      checks++;
      if (act_stretched !== e_act) begin
        errors++;
        $display("FAIL %s act_stretched actual=%0b expected=%0b at cycle %0d", cur_req, act_stretched, e_act, cycles);
      end
    end
  end

  int tick_div = 1;
  int tick_ph = 0;
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % tick_div;
    ms_tick <= (tick_div != 0) && (tick_ph == 0);
  end

  task automatic wr(input bit en, input bit upd, input logic [2:0] ptr, input logic [10:0] d);
    @(negedge clk);
    wr_en = en; wr_update = upd; wr_pointer = ptr; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_update = 0; wr_pointer = 0; wr_data = 0;
  endtask

  function automatic logic [10:0] cfg(int rate, int str);
    return 11'((str << 4) | rate);
  endfunction

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int gap);
    @(negedge clk); act_raw = 1;
    @(negedge clk); act_raw = 0;
    run(gap);
  endtask

  initial begin
    run(3);
    // R9: outputs low while in reset and just after release
    checks++;
    if (blink_out !== 1'b0 || act_stretched !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset outputs actual=%0b%0b expected=00", blink_out, act_stretched);
    end
    @(negedge clk); rst_n = 1;
    compare_on = 1;
    cur_req = "R9"; run(50);

    cur_req = "R4"; wr(1, 1, 3'd6, cfg(2, 1)); run(800);
    cur_req = "R2"; wr(1, 1, 3'd6, cfg(5, 3)); run(1400);
    cur_req = "R2"; wr(1, 1, 3'd6, cfg(7, 2)); run(1400);
    cur_req = "R3"; wr(1, 1, 3'd6, cfg(4, 6)); run(700);
    cur_req = "R3"; wr(1, 1, 3'd6, cfg(3, 4)); run(400);
    cur_req = "R4"; wr(1, 1, 3'd6, cfg(3, 0)); run(400);
    cur_req = "R5"; wr(1, 1, 3'd6, cfg(0, 2)); run(200);
    cur_req = "R5"; wr(1, 1, 3'd6, cfg(1, 2)); run(200);
    cur_req = "R1"; wr(1, 1, 3'd6, cfg(2, 1)); run(30);
    wr(1, 0, 3'd6, cfg(0, 4)); run(200);
    wr(1, 1, 3'd0, cfg(5, 0)); run(200);
    wr(0, 1, 3'd6, cfg(0, 0)); run(200);
    wr(1, 1, 3'd7, cfg(1, 3)); run(200);
    cur_req = "R6"; wr(1, 1, 3'd6, cfg(4, 2)); run(137);
    wr(1, 1, 3'd6, cfg(1, 1)); run(53);
    wr(1, 1, 3'd6, cfg(3, 3)); run(700);
    cur_req = "R10"; tick_div = 0; run(150); tick_div = 1;
    cur_req = "R11"; tick_div = 2; wr(1, 1, 3'd6, cfg(2, 2)); run(600);
    cur_req = "R7";
    pulse(30); pulse(120); pulse(200);
    pulse(10); pulse(10); pulse(300);
    @(negedge clk); act_raw = 1; run(5); act_raw = 0; run(200);
    cur_req = "R7"; tick_div = 1; wr(1, 1, 3'd6, cfg(2, 4)); pulse(100); pulse(250);
    cur_req = "R8"; wr(1, 1, 3'd6, cfg(2, 0));
    pulse(3); pulse(0); pulse(5);
    @(negedge clk); act_raw = 1; run(4); act_raw = 0; run(20);
    cur_req = "R9"; @(negedge clk); rst_n = 0; compare_on = 0;
    @(negedge clk);
    checks++;
    if (blink_out !== 1'b0 || act_stretched !== 1'b0) begin
      errors++;
      $display("FAIL R9 mid-run reset actual=%0b%0b expected=00", blink_out, act_stretched);
    end
    @(negedge clk); rst_n = 1; compare_on = 1; run(300);
    compare_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule